// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block sits in the fetch path and turns each instruction fetch address into a physical address, one request per cycle. It resolves the request through one of four routes, tried in a fixed priority order:

- **Privileged bypass:** a fetch address with bit 0 set skips all translation.
- **Validity check:** an address whose high bits are not a proper sign extension is rejected.
- **Superpage window:** a directly mapped region, open to kernel mode only, when its enable bit is set.
- **Buffer lookup:** otherwise the block consults an attached translation buffer and checks the entry's execute permission for the current mode.

The buffer storage lives outside this block. The block presents the virtual page number and the current address-space number to the buffer, and reads back, in the same cycle, a hit flag, a frame number and a per-mode execute mask.

The response is registered and appears one cycle after the request. It carries:

- a result code;
- the physical address;
- an uncacheable flag.

When a fault is not misspeculated, two internal registers are loaded with the faulting fetch address and with a formatted page-table pointer. This lets the fault handler fetch the missing entry directly.

Top module: `ifetch_xlate`

## Requirements
- R1: While reset is asserted and after its release with no request, rsp_valid, rsp_code, rsp_pa, rsp_uncached, flt_tag and flt_form are all zero.
- R2: A request with fetch_va bit 0 set answers code 0 (no fault) with rsp_pa = fetch_va[39:0] with bits 1:0 cleared and rsp_uncached = 0, regardless of lookup inputs, mode or address validity.
- R3: A non-bypass request whose bits 63:43 are not all equal to bit 42 answers code 1 (access violation).
- R4: A valid non-bypass request with sp_ctl[1] = 1 and fetch_va[42:41] = 2'b10 in kernel mode (cur_mode = 0) answers code 0 with rsp_pa = fetch_va[39:0], ignoring the lookup inputs.
- R5: The same superpage request in any mode other than kernel (1 executive, 2 supervisor, 3 user) answers code 1.
- R6: A request that reaches the lookup with lk_hit = 0 answers code 2 (miss).
- R7: lk_vpn always equals fetch_va[42:13] and lk_asn equals cur_asn. A lookup hit with permission gives rsp_pa = {lk_pfn, fetch_va[12:2], 2'b00}.
- R8: On a lookup hit, bit cur_mode of lk_xmask gates execution: a clear bit answers code 1.
- R9: rsp_uncached is 1 exactly when a superpage or lookup response has code 0 and rsp_pa[39] = 1. Bypass responses are never uncacheable.
- R10: On a fault response with misspec = 0 at request time, flt_tag shows the fetch address and flt_form shows pt_base OR (fetch_va[42:13] << 3) in the same cycle as the response. Otherwise both registers keep their value.
- R11: The response appears the cycle after req_valid. Without a request, rsp_valid is 0 with code 0 and address 0. A fault response carries rsp_pa = 0, and only codes 0, 1 and 2 ever appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request this cycle |
| fetch_va | input | 64 | Fetch virtual address |
| cur_mode | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| sp_ctl | input | 2 | Superpage control, bit 1 opens the window |
| cur_asn | input | 8 | Current address-space number |
| pt_base | input | 64 | Page-table base for the formatted pointer |
| misspec | input | 1 | Request is misspeculated, suppresses fault capture |
| lk_vpn | output | 30 | Virtual page number presented to the buffer |
| lk_asn | output | 8 | Address-space number presented to the buffer |
| lk_hit | input | 1 | Buffer holds a matching entry |
| lk_pfn | input | 27 | Frame number of the matching entry |
| lk_xmask | input | 4 | Execute enable per mode of the matching entry |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | 0 no fault, 1 access violation, 2 miss |
| rsp_pa | output | 40 | Physical address, zero on a fault |
| rsp_uncached | output | 1 | Physical address lies in uncached space |
| flt_tag | output | 64 | Last captured faulting fetch address |
| flt_form | output | 64 | Last captured formatted page-table pointer |

## Verification
A wrong route priority shows up in the very next response. Examples are a superpage check taken before the validity check, or a bypass that still consults the buffer: either yields a wrong code or a wrong address one cycle after the request. Faulty fault-register state is more persistent. A capture made under misspeculation, or one made on a no-fault response, stays visible on flt_tag and flt_form until the next real fault, so these two outputs are compared on every cycle rather than only on fault cycles. Since every mode and every route is driven in turn, an error in the mode-indexed permission select appears as a wrong code in the cycle after the first affected request.

// File: rtl/ifx_pkg.sv
`timescale 1ns/1ps
package ifx_pkg;

    // response result codes, fixed encoding seen at the port
    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_ACV  = 2'd1,
        RES_MISS = 2'd2
    } res_e;

    // kernel is the only mode allowed into the superpage window
    localparam int KERNEL_MODE = 0;

    // page pointer entries are eight bytes wide
    localparam int FORM_SHIFT = 3;

endpackage

// File: rtl/ixl_route.sv
`timescale 1ns/1ps
// Decodes the address-space class of a non-bypass fetch address.
module ixl_route #(
    parameter int HI_W = 22
) (
    input  logic [HI_W-1:0] va_hi,
    input  logic [1:0]      va_space,
    input  logic            sp_open,
    output logic            va_ok,
    output logic            in_window
);

    // sign-extension check: every bit from the top of the
    // implemented range upward must agree
    always_comb begin
        va_ok     = (&va_hi) | (~|va_hi);
        in_window = sp_open && (va_space == 2'b10);
    end

endmodule

// File: rtl/ixl_walk.sv
`timescale 1ns/1ps
// Evaluates the attached buffer's answer: miss, execute permission, address.
module ixl_walk #(
    parameter int PA_W   = 40,
    parameter int PG_W   = 13,
    parameter int MODE_W = 2
) (
    input  logic                   hit,
    input  logic [PA_W-PG_W-1:0]   pfn,
    input  logic [(1<<MODE_W)-1:0] xmask,
    input  logic [MODE_W-1:0]      mode,
    input  logic [PG_W-3:0]        ofs_word,
    output logic                   miss,
    output logic                   perm_ok,
    output logic [PA_W-1:0]        pa
);

    localparam int NMODE = 1 << MODE_W;

    logic [NMODE-1:0] mode_sel;

    // one-hot decode of the mode, one select line per mode
    for (genvar m = 0; m < NMODE; m++) begin : g_mode
        assign mode_sel[m] = (mode == MODE_W'(m));
    end

    always_comb begin
        miss    = !hit;
        perm_ok = |(mode_sel & xmask);
        pa      = {pfn, ofs_word, 2'b00};
    end

endmodule

// File: rtl/ixl_form.sv
`timescale 1ns/1ps
// Builds the formatted page-table pointer for the fault handler.
module ixl_form #(
    parameter int FA_W  = 64,
    parameter int VPN_W = 30,
    parameter int SH    = 3
) (
    input  logic [FA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [FA_W-1:0]  form
);

    localparam int PAD_W = FA_W - VPN_W;

    always_comb begin
        form = base | ({{PAD_W{1'b0}}, vpn} << SH);
    end

endmodule

// File: rtl/ifetch_xlate.sv
`timescale 1ns/1ps
module ifetch_xlate #(
    parameter int FA_W   = 64,
    parameter int VA_W   = 43,
    parameter int PA_W   = 40,
    parameter int PG_W   = 13,
    parameter int MODE_W = 2,
    parameter int ASN_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [FA_W-1:0]         fetch_va,
    input  logic [MODE_W-1:0]       cur_mode,
    input  logic [1:0]              sp_ctl,
    input  logic [ASN_W-1:0]        cur_asn,
    input  logic [FA_W-1:0]         pt_base,
    input  logic                    misspec,
    output logic [VA_W-PG_W-1:0]    lk_vpn,
    output logic [ASN_W-1:0]        lk_asn,
    input  logic                    lk_hit,
    input  logic [PA_W-PG_W-1:0]    lk_pfn,
    input  logic [(1<<MODE_W)-1:0]  lk_xmask,
    output logic                    rsp_valid,
    output logic [1:0]              rsp_code,
    output logic [PA_W-1:0]         rsp_pa,
    output logic                    rsp_uncached,
    output logic [FA_W-1:0]         flt_tag,
    output logic [FA_W-1:0]         flt_form
);

    import ifx_pkg::*;

    localparam int VPN_W = VA_W - PG_W;
    localparam int HI_W  = FA_W - VA_W + 1;

    typedef struct packed {
        logic            vld;
        res_e            code;
        logic [PA_W-1:0] pa;
        logic            unc;
        logic [FA_W-1:0] tag;
        logic [FA_W-1:0] form;
    } st_t;

    st_t st_d, st_q;

    logic            va_ok, in_window;
    logic            walk_miss, walk_perm;
    logic [PA_W-1:0] walk_pa;
    logic [FA_W-1:0] form_val;
    logic [PA_W-1:0] direct_pa;

    ixl_route #(.HI_W(HI_W)) u_route (
        .va_hi     (fetch_va[FA_W-1:VA_W-1]),
        .va_space  (fetch_va[VA_W-1:VA_W-2]),
        .sp_open   (sp_ctl[1]),
        .va_ok     (va_ok),
        .in_window (in_window)
    );

    ixl_walk #(.PA_W(PA_W), .PG_W(PG_W), .MODE_W(MODE_W)) u_walk (
        .hit      (lk_hit),
        .pfn      (lk_pfn),
        .xmask    (lk_xmask),
        .mode     (cur_mode),
        .ofs_word (fetch_va[PG_W-1:2]),
        .miss     (walk_miss),
        .perm_ok  (walk_perm),
        .pa       (walk_pa)
    );

    ixl_form #(.FA_W(FA_W), .VPN_W(VPN_W), .SH(FORM_SHIFT)) u_form (
        .base (pt_base),
        .vpn  (fetch_va[VA_W-1:PG_W]),
        .form (form_val)
    );

    assign direct_pa = fetch_va[PA_W-1:0];
    assign lk_vpn    = fetch_va[VA_W-1:PG_W];
    assign lk_asn    = cur_asn;

    // next-state computation: route priority is bypass, validity,
    // superpage window, then buffer lookup
    always_comb begin
        st_d      = st_q;
        st_d.vld  = req_valid;
        st_d.code = RES_OK;
        st_d.pa   = '0;
        st_d.unc  = 1'b0;
        if (req_valid) begin
            if (fetch_va[0]) begin
                st_d.pa = {direct_pa[PA_W-1:2], 2'b00};
            end else if (!va_ok) begin
                st_d.code = RES_ACV;
            end else if (in_window) begin
                if (cur_mode != MODE_W'(KERNEL_MODE)) begin
                    st_d.code = RES_ACV;
                end else begin
                    st_d.pa  = direct_pa;
                    st_d.unc = direct_pa[PA_W-1];
                end
            end else if (walk_miss) begin
                st_d.code = RES_MISS;
            end else if (!walk_perm) begin
                st_d.code = RES_ACV;
            end else begin
                st_d.pa  = walk_pa;
                st_d.unc = walk_pa[PA_W-1];
            end
            if ((st_d.code != RES_OK) && !misspec) begin
                st_d.tag  = fetch_va;
                st_d.form = form_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.vld;
    assign rsp_code     = st_q.code;
    assign rsp_pa       = st_q.pa;
    assign rsp_uncached = st_q.unc;
    assign flt_tag      = st_q.tag;
    assign flt_form     = st_q.form;

endmodule

// File: rtl/ifetch_xlate_chk.sv
`timescale 1ns/1ps
module ifetch_xlate_chk #(
    parameter int FA_W   = 64,
    parameter int VA_W   = 43,
    parameter int PA_W   = 40,
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [FA_W-1:0]   fetch_va,
    input logic [MODE_W-1:0] cur_mode,
    input logic              sp_on,
    input logic              misspec,
    input logic              lk_hit,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic [PA_W-1:0]   rsp_pa,
    input logic              rsp_uncached,
    input logic [FA_W-1:0]   flt_tag,
    input logic [FA_W-1:0]   flt_form
);

    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && fetch_va[0]) |=>
        (rsp_valid && rsp_code == 2'd0 && !rsp_uncached &&
         rsp_pa == {$past(fetch_va[PA_W-1:2]), 2'b00}));

    p_sp_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fetch_va[0] && sp_on &&
         fetch_va[VA_W-1:VA_W-2] == 2'b10 && cur_mode != '0) |=>
        (rsp_code == 2'd1));

    p_miss_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd2) |-> $past(!lk_hit));

    p_unc_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_uncached |-> (rsp_code == 2'd0 && rsp_pa[PA_W-1]));

    p_tag_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'd0 && !$past(misspec)) |->
        (flt_tag == $past(fetch_va)));

    p_tag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_code != 2'd0 && !$past(misspec)) |->
        ($stable(flt_tag) && $stable(flt_form)));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_code == 2'd0 && rsp_pa == '0));

    p_fault_pa_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != 2'd0) |-> (rsp_pa == '0 && rsp_code != 2'd3));

endmodule

bind ifetch_xlate ifetch_xlate_chk #(
    .FA_W(FA_W), .VA_W(VA_W), .PA_W(PA_W), .MODE_W(MODE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .fetch_va     (fetch_va),
    .cur_mode     (cur_mode),
    .sp_on        (sp_ctl[1]),
    .misspec      (misspec),
    .lk_hit       (lk_hit),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_pa       (rsp_pa),
    .rsp_uncached (rsp_uncached),
    .flt_tag      (flt_tag),
    .flt_form     (flt_form)
);

// File: tb/ifetch_xlate_test.sv
`timescale 1ns/1ps
module ifetch_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] fetch_va = '0;
    logic [1:0]  cur_mode = '0;
    logic [1:0]  sp_ctl = '0;
    logic [7:0]  cur_asn = '0;
    logic [63:0] pt_base = '0;
    logic        misspec = 1'b0;
    logic [29:0] lk_vpn;
    logic [7:0]  lk_asn;
    logic        lk_hit = 1'b0;
    logic [26:0] lk_pfn = '0;
    logic [3:0]  lk_xmask = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [39:0] rsp_pa;
    logic        rsp_uncached;
    logic [63:0] flt_tag;
    logic [63:0] flt_form;

    int n_cmp = 0;
    int n_bad = 0;

    // reference expectations for the next response
    logic [63:0] e_vld, e_code, e_pa, e_unc, e_tag, e_form;
    string       e_req;

    always #4 clk = ~clk;

    ifetch_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fetch_va(fetch_va),
        .cur_mode(cur_mode), .sp_ctl(sp_ctl), .cur_asn(cur_asn),
        .pt_base(pt_base), .misspec(misspec), .lk_vpn(lk_vpn),
        .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .lk_xmask(lk_xmask), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached), .flt_tag(flt_tag),
        .flt_form(flt_form)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(e_vld != 0 ? e_req : "R11", "valid", {63'd0, rsp_valid}, e_vld);
        chk(e_req, "code", {62'd0, rsp_code}, e_code);
        chk(e_req, "pa", {24'd0, rsp_pa}, e_pa);
        chk("R9", "uncached", {63'd0, rsp_uncached}, e_unc);
        chk("R10", "fault tag", flt_tag, e_tag);
        chk("R10", "fault form", flt_form, e_form);
    endtask

    // behavioural reference: decide the outcome of the current inputs
    task automatic predict();
        logic [63:0] hi;
        logic [63:0] pa;
        bit          flt;
        hi  = fetch_va >> 42;
        flt = 0;
        e_vld = {63'd0, req_valid};
        e_code = 0; e_pa = 0; e_unc = 0; e_req = "R11";
        if (req_valid) begin
            if (fetch_va[0] == 1'b1) begin
                e_req = "R2";
                e_pa  = fetch_va & 64'h0000_00FF_FFFF_FFFC;
            end else if (!(hi == 64'd0 || hi == 64'h3F_FFFF)) begin
                e_req = "R3"; e_code = 1; flt = 1;
            end else if (sp_ctl[1] && fetch_va[42:41] == 2'b10) begin
                if (cur_mode != 2'd0) begin
                    e_req = "R5"; e_code = 1; flt = 1;
                end else begin
                    e_req = "R4";
                    e_pa  = fetch_va & 64'h0000_00FF_FFFF_FFFF;
                    e_unc = {63'd0, fetch_va[39]};
                end
            end else if (!lk_hit) begin
                e_req = "R6"; e_code = 2; flt = 1;
            end else if (lk_xmask[cur_mode] == 1'b0) begin
                e_req = "R8"; e_code = 1; flt = 1;
            end else begin
                e_req = "R7";
                pa    = ({37'd0, lk_pfn} << 13) + (fetch_va & 64'h1FFC);
                e_pa  = pa;
                e_unc = {63'd0, pa[39]};
            end
            if (flt && !misspec) begin
                e_tag  = fetch_va;
                e_form = pt_base | (((fetch_va >> 13) & 64'h3FFF_FFFF) << 3);
            end
        end
    endtask

    task automatic step(input bit rv, input logic [63:0] va, input logic [1:0] md,
                        input logic [1:0] sp, input bit ms, input bit hit,
                        input logic [26:0] pfn, input logic [3:0] xm);
        @(negedge clk);
        compare_all();
        req_valid = rv; fetch_va = va; cur_mode = md; sp_ctl = sp;
        misspec = ms; lk_hit = hit; lk_pfn = pfn; lk_xmask = xm;
        cur_asn = va[20:13] ^ 8'h5A;
        pt_base = {va[63:48] ^ 16'h1234, 48'h0};
        #1;
        // R7 lookup key presented combinationally
        chk("R7", "lk_vpn", {34'd0, lk_vpn}, (va >> 13) & 64'h3FFF_FFFF);
        chk("R7", "lk_asn", {56'd0, lk_asn}, {56'd0, cur_asn});
        predict();
    endtask

    localparam logic [63:0] SP_HI = 64'hFFFF_FC00_0000_0000;

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        e_vld = 0; e_code = 0; e_pa = 0; e_unc = 0; e_tag = 0; e_form = 0;
        e_req = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 outputs during reset
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        // R2 bypass, lookup reports a miss and is ignored; bit 39 set but not uncacheable
        step(1, 64'h0000_0080_1234_5677, 2'd3, 2'b00, 0, 0, '0, 4'h0);
        // R2 bypass even with malformed high bits
        step(1, 64'hABCD_0000_0000_0001, 2'd2, 2'b10, 0, 0, '0, 4'h0);
        // R3 malformed high bits
        step(1, 64'h0000_1000_0000_0000, 2'd0, 2'b00, 0, 1, 27'h1, 4'hF);
        // R4 and R9 kernel superpage, uncached space, lookup miss ignored
        step(1, SP_HI | 64'h80_0000_1236, 2'd0, 2'b10, 0, 0, '0, 4'h0);
        // R4 cached superpage
        step(1, SP_HI | 64'h12_3456_789A, 2'd0, 2'b11, 0, 0, '0, 4'h0);
        // R5 superpage in user mode, then supervisor with misspeculation (no capture)
        step(1, SP_HI | 64'h0_0000_2000, 2'd3, 2'b10, 0, 1, 27'h7, 4'hF);
        step(1, SP_HI | 64'h0_0000_4000, 2'd2, 2'b10, 1, 1, 27'h7, 4'hF);
        // R7 window closed (bit 1 clear), goes to lookup
        step(1, SP_HI | 64'h0_0000_6004, 2'd0, 2'b01, 0, 1, 27'h0AB_CDE, 4'h1);
        // R6 miss
        step(1, 64'h0000_0000_1234_5678, 2'd0, 2'b00, 0, 0, 27'h3, 4'hF);
        // R6 miss misspeculated
        step(1, 64'h0000_0000_2234_5678, 2'd1, 2'b00, 1, 0, 27'h3, 4'hF);
        // R8 permission per mode
        step(1, 64'h0000_0000_0000_A3F6, 2'd0, 2'b00, 0, 1, 27'h55, 4'b1110);
        step(1, 64'h0000_0000_0000_A3F4, 2'd3, 2'b00, 0, 1, 27'h55, 4'b1000);
        step(1, 64'h0000_0000_0000_A3F4, 2'd2, 2'b00, 0, 1, 27'h55, 4'b1011);
        step(1, 64'h0000_0000_0000_A3F4, 2'd1, 2'b00, 0, 1, 27'h55, 4'b0010);
        // R9 lookup hit into uncached space
        step(1, 64'h0000_0000_0000_1FFE, 2'd0, 2'b00, 0, 1, 27'h400_0001, 4'h1);
        // R11 idle cycles
        step(0, 64'h0000_0000_0000_1234, 2'd0, 2'b00, 0, 1, 27'h1, 4'hF);
        step(0, '0, 2'd0, 2'b00, 0, 0, '0, 4'h0);
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] va;
            int cat;
            va  = {$urandom, $urandom};
            cat = int'($urandom % 6);
            case (cat)
                0: va = va & 64'h0000_01FF_FFFF_FFFE;
                1: va = (SP_HI | (va & 64'h0000_00FF_FFFF_FFFF)) & ~64'h1;
                2: va = va | 64'h1;
                3: va = (va | 64'hFFFF_FE00_0000_0000) & ~64'h1;
                default: va = va & ~64'h1;
            endcase
            step(($urandom % 8) != 0, va, 2'($urandom), 2'($urandom),
                 ($urandom % 4) == 0, ($urandom % 3) != 0,
                 27'($urandom), 4'($urandom));
        end
        step(0, '0, 2'd0, 2'b00, 0, 0, '0, 4'h0);
        @(negedge clk);
        compare_all();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule